// File: doc/BRIEF.md
# Test Pattern Checker with Lock

This block receives a stream of fixed-width symbols on a valid/ready sink and compares it with one of six expected test patterns: four pseudo-random sequences and two fixed square waves, one high frequency and one low frequency. The checker aligns itself to the incoming data without any marker. Pseudo-random patterns are predicted from bits already received. Fixed patterns are aligned by finding the rotation that matches a received symbol. Once enough clean data has arrived, the checker declares lock. From then on it accumulates a total-bit count and an errored-bit count.

Software controls the checker through a small register port. It can start and stop checking, choose the pattern, read a running flag and a lock flag, read the two 48-bit counters as low and high words, and clear both counters. Any preamble ahead of the pattern is treated as ordinary data that fails to match, so it only delays lock. Symbols are 8 or 10 bits wide, set by a parameter. Within a symbol, bit 0 is the earliest bit in time.

Top module: `pattern_checker`

## Requirements
- R1: Writing register 0 with bit 0 set starts checking, and with bit 1 set stops it; stop wins when both bits are set. Bit 0 of register 0 reads 1 while checking runs. After reset it reads 0.
- R2: Bit 1 of register 0 reads 1 once 64 error-free bits have arrived in a row while running. Lock needs at least 64 consecutive clean bits, so a stream that never matches the selected pattern never locks. Start, stop and any pattern write clear the lock.
- R3: Register 1 selects the pattern in bits 2:0. The codes are 0 = PRBS7, 1 = PRBS15, 2 = PRBS23, 3 = PRBS31, 4 = high-frequency alternating, and 5 = low-frequency half-ones/half-zeros. Register 1 reads the selection back. A write with codes 6 or 7 is ignored.
- R4: In the pseudo-random patterns, each received bit is predicted as the XOR of two earlier received bits. The tap distances are 6 and 7, 14 and 15, 18 and 23, and 28 and 31, so the checker seeds itself from the data.
- R5: The fixed patterns are 0101… (bit 0 = 1) and SYM_W/2 ones followed by SYM_W/2 zeros. While unlocked, a symbol equal to any rotation of the pattern sets the phase and counts as clean. While locked, the stored phase is used.
- R6: Counting happens only on beats that are accepted while running and locked. Each such beat adds SYM_W to the bit counter and adds the number of mismatching bits to the error counter.
- R7: While locked, errors are summed over windows that close at the first symbol boundary at or after 64 bits. When a window's sum exceeds 8, lock drops. A sum of 8 or less keeps lock.
- R8: Writing register 0 with bit 2 set clears both counters. A clear wins over an increment in the same cycle.
- R9: Both counters are 48 bits wide, never decrease except on a clear, and stay at all-ones once they get there.
- R10: Registers 2/3 hold the bit counter low/high and registers 4/5 hold the error counter low/high. Reading a low word captures the upper 16 bits into a shadow that the high-word read returns. Read data appears on the cycle after the read strobe.
- R11: s_ready is always 1. Beats that arrive while checking is stopped change neither the counters nor the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Sink symbol valid |
| s_data | input | SYM_W | Sink symbol, bit 0 earliest |
| s_ready | output | 1 | Sink ready, always high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid the cycle after cfg_rd |

## Verification
The bound checker watches the following properties on every cycle:
- lock only ever rises on an accepted beat, and only while running;
- a stop command leaves the block not running;
- a clear leaves both counters at zero;
- the counters never move while stopped, never decrease, and hold once saturated;
- errors never exceed bits.

Only the bench scenarios can show the following behaviours:
- the lock point for each of the six patterns and their alignment at an arbitrary phase;
- the exact error count for a flipped bit, which is three for the self-seeded sequences and one per bit for the fixed ones;
- lock loss under a burst of errors versus survival under sparse errors;
- the low/high word latching.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

    typedef enum logic [2:0] {
        PAT_P7  = 3'd0,
        PAT_P15 = 3'd1,
        PAT_P23 = 3'd2,
        PAT_P31 = 3'd3,
        PAT_HF  = 3'd4,
        PAT_LF  = 3'd5
    } pat_e;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_PAT  = 3'd1,
        RA_BLO  = 3'd2,
        RA_BHI  = 3'd3,
        RA_ELO  = 3'd4,
        RA_EHI  = 3'd5
    } raddr_e;

    localparam int HIST_W     = 31;  // longest tap distance
    localparam int LOCK_BITS  = 64;  // clean run needed for lock
    localparam int WIN_BITS   = 64;  // error window length
    localparam int LOSS_LIMIT = 8;   // errors tolerated per window

    // Control word decoded from a write to the control register
    typedef struct packed {
        logic start;
        logic stop;
        logic clear;
    } cmd_t;

    function automatic logic is_prbs(pat_e p);
        return (p == PAT_P7) || (p == PAT_P15) || (p == PAT_P23) || (p == PAT_P31);
    endfunction

    function automatic int tap_near(pat_e p);
        case (p)
            PAT_P15: return 14;
            PAT_P23: return 18;
            PAT_P31: return 28;
            default: return 6;
        endcase
    endfunction

    function automatic int tap_far(pat_e p);
        case (p)
            PAT_P15: return 15;
            PAT_P23: return 23;
            PAT_P31: return 31;
            default: return 7;
        endcase
    endfunction

    function automatic logic code_legal(logic [2:0] c);
        return c <= 3'd5;
    endfunction

endpackage

// File: rtl/pchk_expect.sv
module pchk_expect
    import pchk_pkg::*;
#(
    parameter int SYM_W = 8,
    localparam int PH_W = $clog2(SYM_W)
) (
    input  pat_e               pat,
    input  logic [SYM_W-1:0]   rx,
    input  logic [HIST_W-1:0]  hist,
    input  logic               locked,
    input  logic [PH_W-1:0]    phase,
    output logic [SYM_W-1:0]   err_vec,
    output logic [HIST_W-1:0]  hist_nxt,
    output logic               found,
    output logic [PH_W-1:0]    found_ph
);
    localparam int EXT_W = HIST_W + SYM_W;

    logic [EXT_W-1:0] ext;
    logic [SYM_W-1:0] prbs_exp;
    logic [SYM_W-1:0] base;
    logic [SYM_W-1:0] rot [SYM_W];
    logic [SYM_W-1:0] fix_exp;

    function automatic logic [SYM_W-1:0] rotr(input logic [SYM_W-1:0] v, input int k);
        logic [2*SYM_W-1:0] d;
        d = {v, v} >> k;
        return d[SYM_W-1:0];
    endfunction

    // History oldest at bit 0; newest received bit sits at the top
    always_comb begin
        ext      = {rx, hist};
        hist_nxt = ext[EXT_W-1 -: HIST_W];
    end

    always_comb begin
        prbs_exp = '0;
        for (int i = 0; i < SYM_W; i++) begin
            prbs_exp[i] = ext[HIST_W + i - tap_near(pat)] ^ ext[HIST_W + i - tap_far(pat)];
        end
    end

    always_comb begin
        base = '0;
        for (int i = 0; i < SYM_W; i++) begin
            if (pat == PAT_HF) base[i] = ((i % 2) == 0);
            else               base[i] = (i < SYM_W / 2);
        end
    end

    for (genvar g = 0; g < SYM_W; g++) begin : g_rot
        assign rot[g] = rotr(base, g);
    end

    always_comb begin
        found    = 1'b0;
        found_ph = '0;
        for (int k = SYM_W - 1; k >= 0; k--) begin
            if (rx == rot[k]) begin
                found    = 1'b1;
                found_ph = PH_W'(k);
            end
        end
    end

    always_comb begin
        fix_exp = rot[phase];
        if (is_prbs(pat))          err_vec = rx ^ prbs_exp;
        else if (!locked && found) err_vec = '0;
        else                       err_vec = rx ^ fix_exp;
    end

endmodule

// File: rtl/pchk_lock.sv
module pchk_lock
    import pchk_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       beat,
    input  logic [3:0] nerr,
    output logic       locked
);
    logic [7:0] consec;
    logic [7:0] win_bits;
    logic [7:0] win_errs;
    logic [7:0] consec_n;
    logic [7:0] bits_n;
    logic [7:0] errs_n;

    always_comb begin
        consec_n = consec + 8'(SYM_W);
        bits_n   = win_bits + 8'(SYM_W);
        errs_n   = win_errs + 8'(nerr);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            locked   <= 1'b0;
            consec   <= '0;
            win_bits <= '0;
            win_errs <= '0;
        end else if (beat) begin
            if (!locked) begin
                if (nerr != 4'd0) begin
                    consec <= '0;
                end else if (consec_n >= 8'(LOCK_BITS)) begin
                    locked   <= 1'b1;
                    consec   <= '0;
                    win_bits <= '0;
                    win_errs <= '0;
                end else begin
                    consec <= consec_n;
                end
            end else if (errs_n > 8'(LOSS_LIMIT)) begin
                locked   <= 1'b0;
                win_bits <= '0;
                win_errs <= '0;
            end else if (bits_n >= 8'(WIN_BITS)) begin
                win_bits <= '0;
                win_errs <= '0;
            end else begin
                win_bits <= bits_n;
                win_errs <= errs_n;
            end
        end
    end

endmodule

// File: rtl/pchk_satcnt.sv
module pchk_satcnt #(
    parameter int W     = 48,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);
    logic [W:0] sum;

    always_comb sum = {1'b0, cnt} + (W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (en)     cnt <= sum[W] ? '1 : sum[W-1:0];
    end

endmodule

// File: rtl/pchk_regs.sv
module pchk_regs
    import pchk_pkg::*;
#(
    parameter int CNT_W = 48,
    localparam int HI_W = CNT_W - 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             running,
    input  logic             locked,
    input  logic [CNT_W-1:0] bits,
    input  logic [CNT_W-1:0] errs,
    output cmd_t             cmd,
    output logic             pat_wr,
    output pat_e             pat,
    output logic [31:0]      cfg_rdata
);
    logic [HI_W-1:0] bits_hi_q;
    logic [HI_W-1:0] errs_hi_q;
    logic            unused_wdata;

    assign unused_wdata = ^cfg_wdata[31:3];

    always_comb begin
        cmd = '0;
        if (cfg_wr && cfg_addr == RA_CTRL) begin
            cmd.start = cfg_wdata[0];
            cmd.stop  = cfg_wdata[1];
            cmd.clear = cfg_wdata[2];
        end
        pat_wr = cfg_wr && (cfg_addr == RA_PAT) && code_legal(cfg_wdata[2:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)         pat <= PAT_P7;
        else if (pat_wr) pat <= pat_e'(cfg_wdata[2:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= '0;
            bits_hi_q <= '0;
            errs_hi_q <= '0;
        end else if (cfg_rd) begin
            case (cfg_addr)
                RA_CTRL: cfg_rdata <= {30'd0, locked, running};
                RA_PAT:  cfg_rdata <= {29'd0, pat};
                RA_BLO: begin
                    cfg_rdata <= bits[31:0];
                    bits_hi_q <= bits[CNT_W-1:32];
                end
                RA_BHI:  cfg_rdata <= 32'(bits_hi_q);
                RA_ELO: begin
                    cfg_rdata <= errs[31:0];
                    errs_hi_q <= errs[CNT_W-1:32];
                end
                RA_EHI:  cfg_rdata <= 32'(errs_hi_q);
                default: cfg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pattern_checker.sv
module pattern_checker
    import pchk_pkg::*;
#(
    parameter int SYM_W = 8,
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_valid,
    input  logic [SYM_W-1:0] s_data,
    output logic             s_ready,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata
);
    localparam int PH_W = $clog2(SYM_W);

    cmd_t              cmd;
    logic              pat_wr;
    pat_e              pat;
    logic              running;
    logic              locked;
    logic              beat;
    logic              lock_clr;
    logic [HIST_W-1:0] hist;
    logic [HIST_W-1:0] hist_nxt;
    logic [PH_W-1:0]   phase;
    logic [PH_W-1:0]   found_ph;
    logic              found;
    logic [SYM_W-1:0]  err_vec;
    logic [3:0]        nerr;
    logic [CNT_W-1:0]  bits;
    logic [CNT_W-1:0]  errs;

    assign s_ready  = 1'b1;
    assign beat     = s_valid && running;
    assign lock_clr = cmd.start || cmd.stop || pat_wr;
    assign nerr     = 4'($countones(err_vec));

    always_ff @(posedge clk) begin
        if (rst)            running <= 1'b0;
        else if (cmd.stop)  running <= 1'b0;
        else if (cmd.start) running <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            phase <= '0;
        end else if (beat) begin
            hist <= hist_nxt;
            if (!locked && found && !is_prbs(pat)) phase <= found_ph;
        end
    end

    pchk_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .running(running), .locked(locked), .bits(bits), .errs(errs),
        .cmd(cmd), .pat_wr(pat_wr), .pat(pat), .cfg_rdata(cfg_rdata)
    );

    pchk_expect #(.SYM_W(SYM_W)) u_expect (
        .pat(pat), .rx(s_data), .hist(hist), .locked(locked), .phase(phase),
        .err_vec(err_vec), .hist_nxt(hist_nxt), .found(found), .found_ph(found_ph)
    );

    pchk_lock #(.SYM_W(SYM_W)) u_lock (
        .clk(clk), .rst(rst), .clr(lock_clr), .beat(beat), .nerr(nerr), .locked(locked)
    );

    pchk_satcnt #(.W(CNT_W), .INC_W(4)) u_bits (
        .clk(clk), .rst(rst), .clr(cmd.clear), .en(beat && locked),
        .inc(4'(SYM_W)), .cnt(bits)
    );

    pchk_satcnt #(.W(CNT_W), .INC_W(4)) u_errs (
        .clk(clk), .rst(rst), .clr(cmd.clear), .en(beat && locked),
        .inc(nerr), .cnt(errs)
    );

endmodule

// File: rtl/pattern_checker_sva.sv
module pattern_checker_sva #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             running,
    input logic             locked,
    input logic             beat,
    input logic             cfg_wr,
    input logic [2:0]       cfg_addr,
    input logic [31:0]      cfg_wdata,
    input logic [CNT_W-1:0] bits,
    input logic [CNT_W-1:0] errs
);
    logic clr_cmd;
    assign clr_cmd = cfg_wr && (cfg_addr == 3'd0) && cfg_wdata[2];

    AST_LOCK_ON_BEAT: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(beat)); // R2
    AST_LOCK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        locked |-> running); // R2
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_addr == 3'd0 && cfg_wdata[1]) |=> !running); // R1
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> (bits == '0 && errs == '0)); // R8
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!running && !clr_cmd) |=> ($stable(bits) && $stable(errs))); // R11
    AST_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
        !clr_cmd |=> (bits >= $past(bits) && errs >= $past(errs))); // R9
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_cmd && bits == '1) |=> bits == '1); // R9
    AST_ERRS_LE_BITS: assert property (@(posedge clk) disable iff (rst)
        errs <= bits); // R6

endmodule

bind pattern_checker pattern_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst(rst), .running(running), .locked(locked), .beat(beat),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bits(bits), .errs(errs)
);

// File: tb/pattern_checker_tb.sv
`timescale 1ns/1ps
module pattern_checker_tb;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          s_valid = 1'b0;
    logic [SW-1:0] s_data = '0;
    logic          s_ready;
    logic          cfg_wr = 1'b0;
    logic          cfg_rd = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    logic [63:0] h = 64'h9E37_79B9_7F4A_7C15;
    int   fph = 0;

    always #5 clk = ~clk;

    pattern_checker #(.SYM_W(SW), .CNT_W(48)) u_dut (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1 cfg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); cfg_rd = 1'b1; cfg_addr = a;
        @(posedge clk); #1 cfg_rd = 1'b0;
        @(negedge clk); d = cfg_rdata;
    endtask

    task automatic send(logic [SW-1:0] d);
        @(negedge clk); s_valid = 1'b1; s_data = d;
        @(posedge clk); #1 s_valid = 1'b0;
    endtask

    function automatic logic [SW-1:0] rotr(logic [SW-1:0] v, int k);
        logic [2*SW-1:0] t;
        t = {v, v} >> k;
        return t[SW-1:0];
    endfunction

    // Next symbol of pattern p, LSB earliest
    function automatic logic [SW-1:0] gen(int p);
        logic [SW-1:0] s;
        int a;
        int b;
        logic nb;
        s = '0;
        a = (p == 0) ? 6 : (p == 1) ? 14 : (p == 2) ? 18 : 28;
        b = (p == 0) ? 7 : (p == 1) ? 15 : (p == 2) ? 23 : 31;
        if (p < 4) begin
            for (int i = 0; i < SW; i++) begin
                nb   = h[a-1] ^ h[b-1];
                h    = {h[62:0], nb};
                s[i] = nb;
            end
        end else if (p == 4) begin
            s = rotr(8'h55, fph);
        end else begin
            s = rotr(8'h0F, fph);
        end
        return s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] prev;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        rd(3'd0, r); check("R1 reset status", r, 0);
        rd(3'd2, r); check("R6 reset bit count", r, 0);
        rd(3'd4, r); check("R6 reset error count", r, 0);
        check("R11 ready high", s_ready, 1);

        for (int p = 0; p < 6; p++) begin
            wr(3'd1, p); rd(3'd1, r); check("R3 pattern readback", r, p);
        end
        wr(3'd1, 7); rd(3'd1, r); check("R3 illegal code ignored", r, 5);

        for (int p = 0; p < 6; p++) begin
            fph = (p == 4) ? 1 : 3;
            wr(3'd1, p);
            wr(3'd0, 32'h1);
            for (int i = 0; i < 24; i++) send(gen(p));
            rd(3'd0, r); check("R2 locked and running", r, 3);
            wr(3'd0, 32'h4);
            rd(3'd2, r); check("R8 bit count cleared", r, 0);
            for (int i = 0; i < 32; i++) send(gen(p));
            rd(3'd2, r); check("R6 bits counted", r, 32 * SW);
            rd(3'd3, r); check("R10 bit high word", r, 0);
            rd(3'd4, r);
            check(p < 4 ? "R4 clean prbs stream" : "R5 clean fixed stream", r, 0);
            wr(3'd0, 32'h4);
            for (int i = 0; i < 10; i++) send(gen(p));
            send(gen(p) ^ (p < 4 ? 8'h08 : 8'h21));
            for (int i = 0; i < 10; i++) send(gen(p));
            rd(3'd4, r);
            check(p < 4 ? "R4 single flip gives 3 errors" : "R5 two flips give 2 errors",
                  r, p < 4 ? 3 : 2);
            rd(3'd5, r); check("R10 error high word", r, 0);
            rd(3'd2, r); check("R6 bits with errors", r, 21 * SW);
            prev = r;
            rd(3'd0, r); check("R7 lock kept", r, 3);
            wr(3'd0, 32'h2);
            rd(3'd0, r); check("R1 stopped", r, 0);
            for (int i = 0; i < 5; i++) send(gen(p));
            rd(3'd2, r); check("R11 stopped beats ignored", r, prev);
            check("R9 count not decreased", (r >= prev), 1);
        end

        // Wrong pattern: low-frequency data checked as PRBS7
        fph = 0;
        wr(3'd1, 0); wr(3'd0, 32'h5);
        for (int i = 0; i < 40; i++) send(gen(5));
        rd(3'd0, r); check("R2 no lock on mismatch", r, 1);
        rd(3'd2, r); check("R6 no count while unlocked", r, 0);

        // Burst of errors drops lock, realign at new phase
        fph = 0;
        wr(3'd1, 4); wr(3'd0, 32'h1);
        for (int i = 0; i < 16; i++) send(gen(4));
        rd(3'd0, r); check("R2 high-frequency lock", r, 3);
        for (int i = 0; i < 16; i++) send(8'h00);
        rd(3'd0, r); check("R7 lock lost on burst", r, 1);
        fph = 1;
        for (int i = 0; i < 12; i++) send(gen(4));
        rd(3'd0, r); check("R5 relock at new phase", r, 3);

        // Sparse errors: one per 8 symbols keeps lock
        wr(3'd0, 32'h4);
        for (int i = 0; i < 48; i++) send(gen(4) ^ ((i % 8 == 3) ? 8'h01 : 8'h00));
        rd(3'd0, r); check("R7 sparse errors keep lock", r, 3);
        rd(3'd4, r); check("R6 sparse error count", r, 6);
        rd(3'd2, r); check("R6 sparse bit count", r, 48 * SW);

        // Clear and stop in one write: stop wins over start
        wr(3'd0, 32'h7);
        rd(3'd0, r); check("R1 stop wins", r, 0);
        rd(3'd2, r); check("R8 clear with stop", r, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule